// File: doc/BRIEF.md
# 24-bit Periodic Tick Timer

This block is a periodic down-counter for use as an operating-system tick source. Software programs a 24-bit reload value and turns the timer on. On every tick of the chosen reference the count steps down by one. A tick that finds the count at zero copies the reload value back in. Each step from one to zero sets a sticky flag and, if interrupts are on, pulses an interrupt request for one clock cycle.

The reference is either the core clock, so that every cycle is a tick, or an external strobe that marks the ticks of a slower clock. Four word registers sit on a simple single-cycle register bus: control/status at 0x0, reload at 0x4, current value at 0x8 and a read-only calibration word at 0xC.

Reading the control/status register returns the flag and clears it. Writing the current-value register with any data clears both the counter and the flag.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value registers read 0 and the interrupt request is low.
- R2: With control bit 0 (enable) and bit 2 (clock source, 1 = core clock) set, the current value drops by exactly one per clock cycle while it is above zero.
- R3: With bit 2 clear, the counter steps only in cycles where the external tick strobe is high, and stays unchanged otherwise.
- R4: A tick that finds the count at zero loads the reload register (offset 0x4, bits 23:0) into the count.
- R5: A tick that takes the count from one to zero sets the count flag, which reads at bit 16 of the control/status register (offset 0x0).
- R6: A read of control/status returns the flag and then clears it. If the flag is set in the same cycle as that read, setting wins and the flag stays set.
- R7: A write of any data to the current-value register (offset 0x8) makes the count 0 and clears the flag. It wins over a tick in the same cycle.
- R8: The interrupt request goes high for exactly one cycle on each step from one to zero when bit 0 and bit 1 (interrupt enable) are both set. With bit 1 clear it stays low, but the flag is still set.
- R9: With a reload value of zero, the counter stays at zero and the flag is never set.
- R10: With bit 0 clear, the count holds its value whatever the tick sources do.
- R11: Offset 0xC reads the CALIB_VALUE parameter, and writes to it are ignored. Reload reads back only bits 23:0. Control/status reads zero in every bit other than 0, 1, 2 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extTick | input | 1 | External reference tick strobe, one cycle per tick |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (4) | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| tickIrq | output | 1 | Interrupt request pulse |

## Verification
The case hardest to reach from the ports is a flag-clearing read in the same cycle as the step from one to zero. Only that cycle shows whether the flag set wins. The bench runs the timer from the external strobe so that the count moves only when the bench allows it. It steps the count down to one, then raises the strobe in the same cycle as a control/status read, and reads again to see the flag. The same stepping sets up a current-value write that lands on a tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Control/status bit positions (software-visible layout)
  localparam int EnBit      = 0;
  localparam int IrqEnBit   = 1;
  localparam int CoreClkBit = 2;
  localparam int FlagBit    = 16;

  typedef enum logic [1:0] {
    RegCtrl    = 2'd0,
    RegReload  = 2'd1,
    RegCurrent = 2'd2,
    RegCalib   = 2'd3
  } regSel_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic step;        // one reference tick while enabled
    logic clearCount;  // current-value write
    logic readClear;   // control/status read
  } tickStrobe_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int          COUNT_W     = 24,
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] CALIB_VALUE = 32'h0000_3E80
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extTick,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [COUNT_W-1:0] countVal,
  input  logic               flagBit,
  output tickStrobe_t        strobe,
  output logic [COUNT_W-1:0] reloadVal,
  output logic               ctrlEn,
  output logic               ctrlIrqEn,
  output logic               ctrlCoreClk
);

  localparam int PadW = DATA_W - COUNT_W;

  logic    addrOk;
  regSel_e regSel;
  logic    wrHit;
  logic    rdHit;
  logic    unusedBits;

  // Only word-aligned offsets inside the 16-byte window decode
  assign addrOk = (busAddr[1:0] == 2'b00) && ((busAddr >> 4) == '0);
  assign regSel = regSel_e'(busAddr[3:2]);
  assign wrHit  = busSel && busWrite && addrOk;
  assign rdHit  = busSel && !busWrite && addrOk;

  assign unusedBits = &{1'b0, busWdata[DATA_W-1:COUNT_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn      <= 1'b0;
      ctrlIrqEn   <= 1'b0;
      ctrlCoreClk <= 1'b0;
      reloadVal   <= '0;
    end else if (wrHit) begin
      case (regSel)
        RegCtrl: begin
          ctrlEn      <= busWdata[EnBit];
          ctrlIrqEn   <= busWdata[IrqEnBit];
          ctrlCoreClk <= busWdata[CoreClkBit];
        end
        RegReload: reloadVal <= busWdata[COUNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.step       = ctrlEn && (ctrlCoreClk || extTick);
    strobe.clearCount = wrHit && (regSel == RegCurrent);
    strobe.readClear  = rdHit && (regSel == RegCtrl);
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      case (regSel)
        RegCtrl: begin
          busRdata[EnBit]      = ctrlEn;
          busRdata[IrqEnBit]   = ctrlIrqEn;
          busRdata[CoreClkBit] = ctrlCoreClk;
          busRdata[FlagBit]    = flagBit;
        end
        RegReload:  busRdata = {{PadW{1'b0}}, reloadVal};
        RegCurrent: busRdata = {{PadW{1'b0}}, countVal};
        default:    busRdata = CALIB_VALUE;
      endcase
    end
  end

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  tickStrobe_t        strobe,
  input  logic [COUNT_W-1:0] reloadVal,
  input  logic               irqEn,
  output logic [COUNT_W-1:0] countVal,
  output logic               flagBit,
  output logic               tickIrq
);

  localparam logic [COUNT_W-1:0] One = COUNT_W'(1);

  logic atZero;
  logic hitZero;

  assign atZero  = (countVal == '0);
  assign hitZero = strobe.step && (countVal == One) && !strobe.clearCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobe.clearCount) begin
      countVal <= '0;
    end else if (strobe.step) begin
      countVal <= atZero ? reloadVal : countVal - One;
    end
  end

  // Set beats read-clear so an event is never lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagBit <= 1'b0;
    end else if (strobe.clearCount) begin
      flagBit <= 1'b0;
    end else if (hitZero) begin
      flagBit <= 1'b1;
    end else if (strobe.readClear) begin
      flagBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickIrq <= 1'b0;
    else       tickIrq <= hitZero && irqEn;
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int          COUNT_W     = 24,
  parameter int          ADDR_W      = 4,
  parameter logic [31:0] CALIB_VALUE = 32'h0000_3E80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extTick,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              tickIrq
);

  tickStrobe_t        strobe;
  logic [COUNT_W-1:0] countVal;
  logic [COUNT_W-1:0] reloadVal;
  logic               flagBit;
  logic               ctrlEn;
  logic               ctrlIrqEn;
  logic               ctrlCoreClk;

  tick_timer_ctrl #(
    .COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .DATA_W(32), .CALIB_VALUE(CALIB_VALUE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .extTick(extTick),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .countVal(countVal), .flagBit(flagBit), .strobe(strobe),
    .reloadVal(reloadVal), .ctrlEn(ctrlEn), .ctrlIrqEn(ctrlIrqEn),
    .ctrlCoreClk(ctrlCoreClk)
  );

  tick_timer_dp #(.COUNT_W(COUNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .irqEn(ctrlIrqEn), .countVal(countVal), .flagBit(flagBit),
    .tickIrq(tickIrq)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int COUNT_W = 24,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               tickIrq,
  input logic [COUNT_W-1:0] countVal,
  input logic [COUNT_W-1:0] reloadVal,
  input logic               flagBit,
  input logic               ctrlEn,
  input logic               ctrlCoreClk
);

  logic curWr;
  assign curWr = busSel && busWrite && (busAddr == ADDR_W'(8));

  // R2
  core_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && ctrlCoreClk && countVal > COUNT_W'(1) && !curWr)
      |=> countVal == $past(countVal) - COUNT_W'(1));

  // R5
  flag_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagBit) |-> countVal == '0);

  // R7
  cur_write_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    curWr |=> (countVal == '0) && !flagBit);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |=> !tickIrq);

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> flagBit && countVal == '0);

  // R9
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reloadVal == '0 && countVal == '0) |=> countVal == '0 && !$rose(flagBit));

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEn && !curWr) |=> $stable(countVal));

endmodule

bind tick_timer tick_timer_chk #(.COUNT_W(COUNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .tickIrq(tickIrq), .countVal(countVal),
  .reloadVal(reloadVal), .flagBit(flagBit), .ctrlEn(ctrlEn),
  .ctrlCoreClk(ctrlCoreClk)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

  localparam logic [31:0] CalibExp = 32'h0000_3E80;
  localparam logic [3:0]  OffCtrl = 4'h0, OffReload = 4'h4, OffCur = 4'h8, OffCalib = 4'hC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extTick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickIrq;

  int checks = 0;
  int fails = 0;
  int irqSeen = 0;
  int irqWide = 0;
  logic irqPrev = 1'b0;

  tick_timer #(.COUNT_W(24), .ADDR_W(4), .CALIB_VALUE(CalibExp)) uut (
    .clk(clk), .rstN(rstN), .extTick(extTick), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .tickIrq(tickIrq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tickIrq) irqSeen++;
    if (tickIrq && irqPrev) irqWide++;
    irqPrev = tickIrq;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] off, input logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = off; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] off, output logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = off;
    #1 data = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic pulseTick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extTick = 1'b1;
      @(negedge clk); extTick = 1'b0;
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(OffCtrl, d);   check("R1 ctrl", d, 32'h0);
    regRead(OffReload, d); check("R1 reload", d, 32'h0);
    regRead(OffCur, d);    check("R1 current", d, 32'h0);
    check("R1 irq", {31'b0, tickIrq}, 32'h0);
  endtask

  task automatic testExtCount();
    logic [31:0] d;
    regWrite(OffReload, 32'd3);
    regWrite(OffCur, 32'h0);
    regWrite(OffCtrl, 32'h1);
    repeat (5) @(negedge clk);
    regRead(OffCur, d); check("R3 no strobe", d, 32'h0);
    pulseTick(1);
    regRead(OffCur, d); check("R4 reload", d, 32'd3);
    pulseTick(1);
    regRead(OffCur, d); check("R3 step", d, 32'd2);
    pulseTick(2);
    regRead(OffCur, d); check("R5 at zero", d, 32'd0);
    regRead(OffCtrl, d); check("R5 flag set", d, 32'h0001_0001);
    regRead(OffCtrl, d); check("R6 flag cleared", d, 32'h0000_0001);
    pulseTick(1);
    regRead(OffCur, d); check("R4 wrap", d, 32'd3);
  endtask

  task automatic testSetWins();
    logic [31:0] d;
    regWrite(OffReload, 32'd2);
    regWrite(OffCur, 32'h0);
    pulseTick(2);
    regRead(OffCur, d); check("R6 setup", d, 32'd1);
    @(negedge clk);
    extTick = 1'b1; busSel = 1'b1; busWrite = 1'b0; busAddr = OffCtrl;
    #1 d = busRdata;
    check("R6 old flag", d, 32'h0000_0001);
    @(negedge clk);
    extTick = 1'b0; busSel = 1'b0;
    regRead(OffCtrl, d); check("R6 set wins", d, 32'h0001_0001);
  endtask

  task automatic testCurWrite();
    logic [31:0] d;
    regWrite(OffReload, 32'd10);
    regWrite(OffCur, 32'h0);
    pulseTick(11);
    regRead(OffCur, d); check("R7 setup", d, 32'd0);
    pulseTick(3);
    regRead(OffCur, d); check("R7 setup count", d, 32'd8);
    regWrite(OffCur, 32'hABCDEF);
    regRead(OffCur, d); check("R7 count cleared", d, 32'd0);
    regRead(OffCtrl, d); check("R7 flag cleared", d, 32'h0000_0001);
    pulseTick(2);
    @(negedge clk);
    extTick = 1'b1; busSel = 1'b1; busWrite = 1'b1; busAddr = OffCur; busWdata = 32'h5;
    @(negedge clk);
    extTick = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    regRead(OffCur, d); check("R7 beats tick", d, 32'd0);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    regWrite(OffCtrl, 32'h3);
    regWrite(OffReload, 32'd2);
    regWrite(OffCur, 32'h0);
    irqSeen = 0; irqWide = 0;
    pulseTick(6);
    repeat (2) @(negedge clk);
    check("R8 irq count", irqSeen, 2);
    check("R8 irq width", irqWide, 0);
    regWrite(OffCtrl, 32'h1);
    regRead(OffCtrl, d);
    irqSeen = 0;
    pulseTick(3);
    repeat (2) @(negedge clk);
    check("R8 irq masked", irqSeen, 0);
    regRead(OffCtrl, d); check("R8 flag still set", d, 32'h0001_0001);
  endtask

  task automatic testZeroReload();
    logic [31:0] d;
    regWrite(OffReload, 32'd0);
    regWrite(OffCur, 32'h0);
    pulseTick(5);
    regRead(OffCur, d);  check("R9 stays zero", d, 32'd0);
    regRead(OffCtrl, d); check("R9 no flag", d, 32'h0000_0001);
  endtask

  task automatic testHold();
    logic [31:0] d;
    regWrite(OffReload, 32'd50);
    regWrite(OffCur, 32'h0);
    pulseTick(4);
    regWrite(OffCtrl, 32'h4);
    pulseTick(5);
    repeat (10) @(negedge clk);
    regRead(OffCur, d); check("R10 hold", d, 32'd47);
  endtask

  task automatic testCoreClk();
    logic [31:0] v1, v2;
    regWrite(OffReload, 32'h1000);
    regWrite(OffCur, 32'h0);
    regWrite(OffCtrl, 32'h5);
    repeat (3) @(negedge clk);
    regRead(OffCur, v1);
    repeat (9) @(posedge clk);
    regRead(OffCur, v2);
    check("R2 ten cycles", v2, v1 - 32'd10);
    regWrite(OffCtrl, 32'h0);
  endtask

  task automatic testFields();
    logic [31:0] d;
    regRead(OffCalib, d); check("R11 calib", d, CalibExp);
    regWrite(OffCalib, 32'h1234_5678);
    regRead(OffCalib, d); check("R11 calib ro", d, CalibExp);
    regWrite(OffReload, 32'hFFFF_FFFF);
    regRead(OffReload, d); check("R11 reload width", d, 32'h00FF_FFFF);
    regRead(OffCtrl, d);
    regWrite(OffCtrl, 32'hFFFE_FFF8);
    regRead(OffCtrl, d); check("R11 ctrl spare bits", d, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testExtCount();
    testSetWins();
    testCurWrite();
    testIrq();
    testZeroReload();
    testHold();
    testCoreClk();
    testFields();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule